// File: doc/BRIEF.md
# Repeating Block Copy Engine

This block runs a byte-copy instruction for an accumulator-based processor that addresses memory as an 8-bit bank plus a 16-bit offset. Once started, it reads two operand bytes that follow the opcode. The first is the destination bank and the second is the source bank. It then moves one byte from source bank:X to destination bank:Y and steps both index registers by one, upward or downward.

After each byte it decrements the 16-bit accumulator and winds the program counter back by three, so the same instruction runs again. This repeats until the accumulator wraps from zero to all ones. A starting count of N therefore copies N+1 bytes.

The block talks to memory over a byte-wide bus with read and write strobes. Read data comes back in the same cycle as the strobe, so each access takes one clock. A cycle-type code reports every bus cycle as a read, a write or an idle cycle. The register values enter through load ports when `start` is accepted and leave through registered output ports.

Top module: `bmv_engine`

## Requirements
- R1: Each pass first reads the destination bank byte at {pbank_in, PC+1} and then the source bank byte at {pbank_in, PC+2}, where PC is the opcode address. Both offsets wrap within 16 bits.
- R2: The destination bank output is reloaded with the first operand byte on every pass.
- R3: After the two operand reads, one read at {source bank, X} is followed in the next cycle by a write to {destination bank, Y} that carries the byte just read.
- R4: The write is followed by exactly two cycles with no strobe and cycle type 00, with busy held high.
- R5: When index width is 16 bits (idx8 = 0), X and Y both change by +1 if dir_dec = 0, or by -1 if dir_dec = 1, modulo 2^16. The new values are visible from the second idle cycle on.
- R6: When idx8 = 1, only bits 7:0 of X and Y step, modulo 256, and bits 15:8 keep their value.
- R7: The accumulator drops by one at the end of each pass. A count of N performs N+1 writes and leaves the accumulator at 16'hFFFF.
- R8: Between passes the program counter returns to the opcode address, which is its value plus 3, minus 3. At completion it holds the opcode address plus 3, modulo 2^16.
- R9: `done` is high for exactly one cycle after the final pass, and busy is low in that cycle.
- R10: cyc_type is 01 in a read cycle, 10 in a write cycle and 00 otherwise. mem_rd and mem_wr are never high together.
- R11: `start` and the load inputs are ignored while busy.
- R12: After reset, busy, done, both strobes and cyc_type are 0, and the register outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the instruction (sampled when idle) |
| dir_dec | input | 1 | 1: indexes step down, 0: step up |
| idx8 | input | 1 | 1: 8-bit index mode |
| acc_in | input | 16 | Starting count |
| x_in | input | 16 | Starting source offset |
| y_in | input | 16 | Starting destination offset |
| pc_in | input | 16 | Opcode address |
| pbank_in | input | 8 | Program bank |
| mem_addr | output | 24 | Bus address {bank, offset} |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the strobe cycle |
| cyc_type | output | 2 | 00 idle, 01 read, 10 write |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 16 | Accumulator |
| x_out | output | 16 | X index |
| y_out | output | 16 | Y index |
| pc_out | output | 16 | Program counter |
| dbank_out | output | 8 | Data bank (last destination bank) |

## Verification
Some properties are checked by assertions on every cycle:
- the two strobes never overlap;
- a write is always preceded by a read and followed by two quiet cycles;
- `done` lasts a single cycle;
- the accumulator drops by one per pass;
- the PC rewinds by three on a repeat;
- narrow mode keeps the index high bytes.

Other behaviour can only be shown by the bench scenarios, which compare every bus cycle against a model:
- the exact operand and data addresses;
- the byte written;
- the step direction and wrap points of X and Y;
- the total byte count for a given accumulator;
- that `start` has no effect mid-run.

// File: rtl/bmv_pkg.sv
package bmv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPD, ST_OPS, ST_RD, ST_WR, ST_IO1, ST_IO2
  } bmv_st_t;

  localparam logic [1:0] CY_IDLE  = 2'b00;
  localparam logic [1:0] CY_READ  = 2'b01;
  localparam logic [1:0] CY_WRITE = 2'b10;
endpackage

// File: rtl/bmv_seq.sv
module bmv_seq
  import bmv_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    more,
  output bmv_st_t st,
  output logic    ld,
  output logic    step,
  output logic    pass_end,
  output logic    done
);
  bmv_st_t st_q;

  assign st       = st_q;
  assign ld       = (st_q == ST_IDLE) && start;
  assign step     = (st_q == ST_IO1);
  assign pass_end = (st_q == ST_IO2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_OPD;
        ST_OPD:  st_q <= ST_OPS;
        ST_OPS:  st_q <= ST_RD;
        ST_RD:   st_q <= ST_WR;
        ST_WR:   st_q <= ST_IO1;
        ST_IO1:  st_q <= ST_IO2;
        ST_IO2: begin
          if (more) st_q <= ST_OPD;
          else begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: completion pulse lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11: a busy sequencer never returns to the load point on start alone
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD && start) |=> st_q == ST_WR);
endmodule

// File: rtl/bmv_index.sv
module bmv_index #(
  parameter int W      = 16,
  parameter int LOW_W  = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         dec,
  input  logic         narrow,
  output logic [W-1:0] q
);
  localparam int HI_W = W - LOW_W;

  logic [LOW_W-1:0] lo_next;
  logic [W-1:0]     full_next;

  always_comb begin
    lo_next   = dec ? q[LOW_W-1:0] - LOW_W'(1) : q[LOW_W-1:0] + LOW_W'(1);
    full_next = dec ? q - W'(1) : q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load) q <= load_val;
    else if (step) begin
      if (narrow) q <= {q[W-1:LOW_W], lo_next};
      else        q <= full_next;
    end
  end

  // R6: narrow stepping leaves the high part untouched
  p_hi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (step && narrow && !load) |=> q[W-1:W-HI_W] == $past(q[W-1:W-HI_W]));
endmodule

// File: rtl/bmv_count.sv
module bmv_count #(
  parameter int W      = 16,
  parameter int REWIND = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] pc_in,
  input  logic         fetch_end,
  input  logic         pass_end,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] pc_q,
  output logic         more
);
  assign more = (acc_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      pc_q  <= '0;
    end else if (load) begin
      acc_q <= acc_in;
      pc_q  <= pc_in;
    end else begin
      if (fetch_end) pc_q <= pc_q + W'(REWIND);
      if (pass_end) begin
        acc_q <= acc_q - W'(1);
        if (more) pc_q <= pc_q - W'(REWIND);
      end
    end
  end

  // R7: one decrement per pass
  p_acc_step_r7: assert property (@(posedge clk) disable iff (rst)
    pass_end |=> acc_q == $past(acc_q) - W'(1));
  // R8: a repeating pass rewinds the program counter
  p_pc_rewind_r8: assert property (@(posedge clk) disable iff (rst)
    (pass_end && acc_q != '0) |=> pc_q == $past(pc_q) - W'(REWIND));
endmodule

// File: rtl/bmv_engine.sv
module bmv_engine
  import bmv_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 16,
  parameter int NARROW_W = 8,
  parameter int REWIND   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      dir_dec,
  input  logic                      idx8,
  input  logic [OFF_W-1:0]          acc_in,
  input  logic [OFF_W-1:0]          x_in,
  input  logic [OFF_W-1:0]          y_in,
  input  logic [OFF_W-1:0]          pc_in,
  input  logic [DATA_W-1:0]         pbank_in,
  output logic [DATA_W+OFF_W-1:0]   mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic [1:0]                cyc_type,
  output logic                      busy,
  output logic                      done,
  output logic [OFF_W-1:0]          acc_out,
  output logic [OFF_W-1:0]          x_out,
  output logic [OFF_W-1:0]          y_out,
  output logic [OFF_W-1:0]          pc_out,
  output logic [DATA_W-1:0]         dbank_out
);
  localparam int ADDR_W = DATA_W + OFF_W;
  localparam int NIDX   = 2;

  bmv_st_t           st;
  logic              ld, step, pass_end, more;
  logic [DATA_W-1:0] pb_q, db_q, sb_q, dat_q;
  logic              dir_q, nar_q;
  logic [OFF_W-1:0]  idx_in [NIDX];
  logic [OFF_W-1:0]  idx_q  [NIDX];

  bmv_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .more(more), .st(st),
    .ld(ld), .step(step), .pass_end(pass_end), .done(done)
  );

  bmv_count #(.W(OFF_W), .REWIND(REWIND)) u_count (
    .clk(clk), .rst(rst), .load(ld), .acc_in(acc_in), .pc_in(pc_in),
    .fetch_end(st == ST_OPS), .pass_end(pass_end),
    .acc_q(acc_out), .pc_q(pc_out), .more(more)
  );

  assign idx_in[0] = x_in;
  assign idx_in[1] = y_in;

  for (genvar i = 0; i < NIDX; i++) begin : g_idx
    bmv_index #(.W(OFF_W), .LOW_W(NARROW_W)) u_idx (
      .clk(clk), .rst(rst), .load(ld), .load_val(idx_in[i]),
      .step(step), .dec(dir_q), .narrow(nar_q), .q(idx_q[i])
    );
  end

  assign x_out     = idx_q[0];
  assign y_out     = idx_q[1];
  assign dbank_out = db_q;
  assign busy      = (st != ST_IDLE);
  assign mem_wdata = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pb_q  <= '0;
      db_q  <= '0;
      sb_q  <= '0;
      dat_q <= '0;
      dir_q <= 1'b0;
      nar_q <= 1'b0;
    end else begin
      if (ld) begin
        pb_q  <= pbank_in;
        dir_q <= dir_dec;
        nar_q <= idx8;
      end
      if (st == ST_OPD) db_q  <= mem_rdata;
      if (st == ST_OPS) sb_q  <= mem_rdata;
      if (st == ST_RD)  dat_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_addr = '0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    cyc_type = CY_IDLE;
    case (st)
      ST_OPD: begin
        mem_addr = {pb_q, pc_out + OFF_W'(1)};
        mem_rd   = 1'b1;
        cyc_type = CY_READ;
      end
      ST_OPS: begin
        mem_addr = {pb_q, pc_out + OFF_W'(2)};
        mem_rd   = 1'b1;
        cyc_type = CY_READ;
      end
      ST_RD: begin
        mem_addr = {sb_q, idx_q[0]};
        mem_rd   = 1'b1;
        cyc_type = CY_READ;
      end
      ST_WR: begin
        mem_addr = {db_q, idx_q[1]};
        mem_wr   = 1'b1;
        cyc_type = CY_WRITE;
      end
      default: ;
    endcase
  end

  // R10: strobes never overlap
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R3: every write directly follows a read
  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd));
  // R4: two quiet busy cycles after a write
  p_quiet_one_r4: assert property (@(posedge clk) disable iff (rst)
    $past(mem_wr) |-> (cyc_type == CY_IDLE && busy));
  p_quiet_two_r4: assert property (@(posedge clk) disable iff (rst)
    $past(mem_wr, 2) |-> (cyc_type == CY_IDLE && busy && !mem_rd));
  // R2: data bank follows the destination operand read
  p_dbank_load_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OPD) |=> dbank_out == $past(mem_rdata));
endmodule

// File: tb/sim_bmv_engine.sv
module sim_bmv_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, dir_dec = 1'b0, idx8 = 1'b0;
  logic [15:0] acc_in = '0, x_in = '0, y_in = '0, pc_in = '0;
  logic [7:0]  pbank_in = '0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, busy, done;
  logic [7:0]  mem_wdata, mem_rdata, dbank_out;
  logic [1:0]  cyc_type;
  logic [15:0] acc_out, x_out, y_out, pc_out;

  int tests = 0, fails = 0;
  logic [7:0]  m_pb = '0, m_db = '0, m_sb = '0;
  logic [15:0] m_pc = '0;

  always #10 clk = ~clk;

  bmv_engine u0 (
    .clk(clk), .rst(rst), .start(start), .dir_dec(dir_dec), .idx8(idx8),
    .acc_in(acc_in), .x_in(x_in), .y_in(y_in), .pc_in(pc_in),
    .pbank_in(pbank_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cyc_type(cyc_type), .busy(busy), .done(done), .acc_out(acc_out),
    .x_out(x_out), .y_out(y_out), .pc_out(pc_out), .dbank_out(dbank_out)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] v, input logic dec,
                                      input logic nar);
    logic [7:0] lo;
    lo = dec ? v[7:0] - 8'd1 : v[7:0] + 8'd1;
    if (nar) return {v[15:8], lo};
    return dec ? v - 16'd1 : v + 16'd1;
  endfunction

  always_comb begin
    if (mem_addr == {m_pb, 16'(m_pc + 16'd1)})      mem_rdata = m_db;
    else if (mem_addr == {m_pb, 16'(m_pc + 16'd2)}) mem_rdata = m_sb;
    else                                            mem_rdata = pat(mem_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_move(input logic [15:0] pc, input logic [7:0] pb,
                          input logic [7:0] db, input logic [7:0] sb,
                          input logic [15:0] acc, input logic [15:0] x,
                          input logic [15:0] y, input logic dec,
                          input logic nar, input bit noisy);
    logic [15:0] ex, ey;
    int writes;
    ex = x; ey = y; writes = 0;
    m_pc = pc; m_pb = pb; m_db = db; m_sb = sb;
    @(negedge clk);
    pc_in = pc; pbank_in = pb; acc_in = acc; x_in = x; y_in = y;
    dir_dec = dec; idx8 = nar; start = 1'b1;
    @(posedge clk);
    for (int p = 0; p <= int'(acc); p++) begin
      @(negedge clk);
      if (!noisy) start = 1'b0;
      else begin acc_in = 16'($urandom); x_in = 16'($urandom); end
      chk(mem_rd && mem_addr == {pb, 16'(pc + 16'd1)}, "R1 dest operand addr",
          32'(mem_addr), 32'({pb, 16'(pc + 16'd1)}));
      @(posedge clk); @(negedge clk);
      chk(mem_rd && mem_addr == {pb, 16'(pc + 16'd2)}, "R1 src operand addr",
          32'(mem_addr), 32'({pb, 16'(pc + 16'd2)}));
      chk(pc_out == pc, "R8 pc at opcode", 32'(pc_out), 32'(pc));
      @(posedge clk); @(negedge clk);
      chk(mem_rd && mem_addr == {sb, ex}, "R3 source read",
          32'(mem_addr), 32'({sb, ex}));
      chk(dbank_out == db, "R2 data bank", 32'(dbank_out), 32'(db));
      chk(cyc_type == 2'b01, "R10 read code", 32'(cyc_type), 32'd1);
      @(posedge clk); @(negedge clk);
      chk(mem_wr && !mem_rd && mem_addr == {db, ey}, "R3 dest write",
          32'(mem_addr), 32'({db, ey}));
      chk(mem_wdata == pat({sb, ex}), "R3 write data",
          32'(mem_wdata), 32'(pat({sb, ex})));
      chk(cyc_type == 2'b10, "R10 write code", 32'(cyc_type), 32'd2);
      if (mem_wr) writes++;
      @(posedge clk); @(negedge clk);
      chk(cyc_type == 2'b00 && !mem_rd && !mem_wr && busy, "R4 idle one",
          32'(cyc_type), 32'd0);
      ex = nxt(ex, dec, nar); ey = nxt(ey, dec, nar);
      @(posedge clk); @(negedge clk);
      chk(cyc_type == 2'b00 && !mem_rd && !mem_wr && busy, "R4 idle two",
          32'(cyc_type), 32'd0);
      chk(x_out == ex, nar ? "R6 x narrow step" : "R5 x step",
          32'(x_out), 32'(ex));
      chk(y_out == ey, nar ? "R6 y narrow step" : "R5 y step",
          32'(y_out), 32'(ey));
      chk(acc_out == 16'(acc - 16'(p)), "R7 count before dec",
          32'(acc_out), 32'(16'(acc - 16'(p))));
      if (p == int'(acc)) start = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    chk(done && !busy, "R9 done pulse", 32'({done, busy}), 32'h2);
    chk(acc_out == 16'hFFFF, "R7 final count", 32'(acc_out), 32'hFFFF);
    chk(writes == int'(acc) + 1, "R7 byte total", 32'(writes),
        32'(int'(acc) + 1));
    chk(pc_out == 16'(pc + 16'd3), "R8 final pc", 32'(pc_out),
        32'(16'(pc + 16'd3)));
    chk(x_out == ex && y_out == ey, "R11 inputs ignored while busy",
        32'(x_out), 32'(ex));
    @(posedge clk); @(negedge clk);
    chk(!done && !busy, "R9 done drops", 32'({done, busy}), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && cyc_type == 2'b00,
        "R12 reset controls", 32'({busy, done, mem_rd, mem_wr}), 32'h0);
    chk(acc_out == 0 && x_out == 0 && y_out == 0 && pc_out == 0,
        "R12 reset registers", 32'(acc_out), 32'h0);
    rst = 1'b0;
    // directed corners
    run_move(16'h1000, 8'h01, 8'h82, 8'h93, 16'd0, 16'h0010, 16'h0020,
             1'b0, 1'b0, 1'b0);
    run_move(16'h2000, 8'h02, 8'h84, 8'h85, 16'd3, 16'h12FE, 16'h3401,
             1'b0, 1'b1, 1'b0);
    run_move(16'h3000, 8'h03, 8'h86, 8'h87, 16'd2, 16'h5601, 16'h7801,
             1'b1, 1'b1, 1'b0);
    run_move(16'hFFFE, 8'h04, 8'h88, 8'h89, 16'd2, 16'hFFFE, 16'h0001,
             1'b0, 1'b0, 1'b0);
    run_move(16'h4000, 8'h05, 8'h8A, 8'h8B, 16'd3, 16'h0001, 16'hFFFF,
             1'b1, 1'b0, 1'b1);
    // random mix
    for (int i = 0; i < 24; i++) begin
      run_move(16'($urandom), {1'b0, 7'($urandom)}, 8'($urandom),
               {1'b1, 7'($urandom)}, 16'($urandom_range(0, 5)),
               16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
               bit'($urandom_range(0, 1)));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule